// File: doc/BRIEF.md
# Split-Byte Conversion Result Holder

This block keeps the most recent 10-bit result delivered by an analog-to-digital converter. It lets an 8-bit CPU fetch that result as two bytes: a low byte and a high byte. A mode bit picks the justification. In right-justified mode the ten bits sit at the bottom of the 16-bit pair. In left-justified mode they sit at the top, so the high byte alone carries an 8-bit approximation.

A read of the low byte starts an atomic pair. From that point the stored result ignores new conversions until the high byte is read, so the two bytes always come from one conversion. A high-byte read on its own never locks the holder. Software that only wants 8 bits in left-justified mode can therefore keep reading the high byte. The read data is combinational: the byte selected by the strobe appears in the same cycle.

Top module: `adc_result_latch`

## Requirements
- R1: After reset the stored result is 0 and the holder is unlocked. Reads of either byte return 0x00.
- R2: With `left_adj` = 0, a low-byte read returns result bits 7:0.
- R3: With `left_adj` = 0, a high-byte read returns result bits 9:8 in bits 1:0. Bits 7:2 read as 0.
- R4: With `left_adj` = 1, a high-byte read returns result bits 9:2.
- R5: With `left_adj` = 1, a low-byte read returns result bits 1:0 in bits 7:6. Bits 5:0 read as 0.
- R6: A `conv_done` pulse while unlocked, with no low-byte read in that cycle, stores `conv_data`. Reads from the next cycle show the new value.
- R7: A low-byte read locks the holder. While locked, every completed conversion is discarded, including one in the same cycle as the unlocking high-byte read. The lock clears after the high-byte read.
- R8: A high-byte read while unlocked does not lock the holder. A later conversion is still stored.
- R9: A conversion that completes in the same cycle as a low-byte read is discarded.
- R10: A change of `left_adj` changes the byte layout in the same cycle, without a new conversion.
- R11: With neither strobe active, `rd_data` is 0x00. With both strobes active in one cycle, `rd_data` shows the low byte and the holder ends unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | One-cycle pulse: a conversion has finished |
| conv_data | input | 10 | Result of the finished conversion |
| left_adj | input | 1 | 1 = left-justified layout, 0 = right-justified |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| rd_data | output | 8 | Selected byte, 0 when no strobe is active |

## Verification
Byte reads and justification changes are due in the same cycle as the strobe. A stored conversion shows up on reads from the cycle after its `conv_done` pulse. The driver applies inputs on the falling edge and queues the expected byte for that same cycle. The monitor checks the queued byte one nanosecond later, before the next rising edge. Any read that should see a new conversion is issued at least one cycle after the pulse.

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              left_adj,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int HI_BITS = RES_W - BYTE_W;
  localparam int PAD_W   = BYTE_W - HI_BITS;

  logic [RES_W-1:0] res_q;
  logic             locked_q;
  logic             take;

  assign take = conv_done && !locked_q && !rd_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (take) res_q <= conv_data;
      if (rd_hi)      locked_q <= 1'b0;
      else if (rd_lo) locked_q <= 1'b1;
    end
  end

  logic [BYTE_W-1:0] lo_view, hi_view;

  assign lo_view = left_adj ? {res_q[HI_BITS-1:0], {PAD_W{1'b0}}}
                            : res_q[BYTE_W-1:0];
  assign hi_view = left_adj ? res_q[RES_W-1:RES_W-BYTE_W]
                            : {{PAD_W{1'b0}}, res_q[RES_W-1:BYTE_W]};

  assign rd_data = rd_lo ? lo_view : (rd_hi ? hi_view : '0);
endmodule

// File: rtl/adc_result_latch_chk.sv
module adc_result_latch_chk #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic [RES_W-1:0]  conv_data,
  input logic              left_adj,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic [BYTE_W-1:0] rd_data,
  input logic [RES_W-1:0]  res_q,
  input logic              locked_q
);
  localparam int PAD_W = 2 * BYTE_W - RES_W;

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(res_q)); // R7
  AST_LO_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> $stable(res_q)); // R9
  AST_HI_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_q && rd_hi && !rd_lo) |=> !locked_q); // R8
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !locked_q && !rd_lo) |=> res_q == $past(conv_data)); // R6
  AST_RJ_HI_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !rd_lo && !left_adj) |-> rd_data[BYTE_W-1:BYTE_W-PAD_W] == '0); // R3
  AST_LJ_LO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && left_adj) |-> rd_data[PAD_W-1:0] == '0); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !rd_hi) |-> rd_data == '0); // R11
  AST_BOTH_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && rd_hi) |=> !locked_q); // R11
endmodule

bind adc_result_latch adc_result_latch_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
  .left_adj(left_adj), .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data),
  .res_q(res_q), .locked_q(locked_q)
);

// File: tb/adc_result_latch_test.sv
module adc_result_latch_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic       left_adj = 1'b0;
  logic       rd_lo = 1'b0;
  logic       rd_hi = 1'b0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  adc_result_latch uut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .left_adj(left_adj), .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data)
  );

  task automatic cyc(input bit d, input logic [9:0] v, input bit adj,
                     input bit lo, input bit hi, input bit chk,
                     input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    conv_done = d;
    conv_data = v;
    left_adj  = adj;
    rd_lo     = lo;
    rd_hi     = hi;
    if (chk) begin
      it.exp = exp;
      it.tag = tag;
      sb.push_back(it);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (rd_data !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%02h expected=%02h", it.tag, rd_data, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 1, 8'h00, "R1 idle after reset");
    cyc(0, 0, 0, 1, 0, 1, 8'h00, "R1 low byte after reset");
    cyc(0, 0, 0, 0, 1, 1, 8'h00, "R1 high byte after reset");
    // R6 store and R2/R3 right layout
    cyc(1, 10'h2A5, 0, 0, 0, 0, 8'h00, "");
    cyc(0, 0, 0, 1, 0, 1, 8'hA5, "R2 right low byte");
    cyc(0, 0, 0, 0, 1, 1, 8'h02, "R3 right high byte");
    // R4/R5/R10 left layout of same value
    cyc(0, 0, 1, 0, 1, 1, 8'hA9, "R4 left high byte");
    cyc(0, 0, 1, 1, 0, 1, 8'h40, "R5 left low byte");
    cyc(0, 0, 1, 0, 1, 1, 8'hA9, "R10 left high byte");
    // R8 high-only reads do not lock
    cyc(1, 10'h3FF, 1, 0, 0, 0, 8'h00, "");
    cyc(0, 0, 1, 0, 1, 1, 8'hFF, "R8 high read 3FF");
    cyc(1, 10'h155, 1, 0, 0, 0, 8'h00, "");
    cyc(0, 0, 1, 0, 1, 1, 8'h55, "R8 new value after high-only read");
    // R7 lock discards conversions
    cyc(0, 0, 0, 1, 0, 1, 8'h55, "R7 low byte locks");
    cyc(1, 10'h0F0, 0, 0, 0, 0, 8'h00, "");
    cyc(1, 10'h0F0, 0, 0, 1, 1, 8'h01, "R7 high byte keeps old");
    cyc(0, 0, 0, 1, 0, 1, 8'h55, "R7 discarded while locked");
    cyc(0, 0, 0, 0, 1, 1, 8'h01, "R7 old high byte");
    cyc(1, 10'h0F0, 0, 0, 0, 0, 8'h00, "");
    cyc(0, 0, 0, 1, 0, 1, 8'hF0, "R6 accepted after unlock");
    cyc(0, 0, 0, 0, 1, 1, 8'h00, "R6 high byte of 0F0");
    // R9 conversion in the same cycle as a low read
    cyc(1, 10'h123, 0, 1, 0, 1, 8'hF0, "R9 low byte same cycle");
    cyc(0, 0, 0, 0, 1, 1, 8'h00, "R9 high byte keeps old");
    cyc(0, 0, 0, 1, 0, 1, 8'hF0, "R9 conversion discarded");
    cyc(0, 0, 0, 0, 1, 1, 8'h00, "R9 pair closed");
    // R10 immediate mode change
    cyc(0, 0, 1, 0, 1, 1, 8'h3C, "R10 left high of 0F0");
    cyc(0, 0, 1, 1, 0, 1, 8'h00, "R10 left low of 0F0");
    cyc(0, 0, 0, 0, 1, 1, 8'h00, "R10 right high of 0F0");
    // R11 idle zero and both strobes
    cyc(0, 0, 0, 0, 0, 1, 8'h00, "R11 idle zero");
    cyc(0, 0, 0, 1, 1, 1, 8'hF0, "R11 both strobes show low");
    cyc(1, 10'h3C7, 0, 0, 0, 0, 8'h00, "");
    cyc(0, 0, 0, 0, 1, 1, 8'h03, "R11 unlocked after both strobes");
    cyc(0, 0, 0, 1, 0, 1, 8'hC7, "R11 new low byte");
    cyc(0, 0, 0, 0, 1, 1, 8'h03, "R11 close pair");
    cyc(0, 0, 0, 0, 0, 0, 8'h00, "");
    @(negedge clk);
    #2;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule